// File: doc/BRIEF.md
# Soft Interrupt Pending Register

This block holds a 17-bit vector of pending software interrupts and a 4-bit processor interrupt level (PIL) for one core. It turns the pair into one interrupt request line per vector bit, which the trap logic consumes. Software reaches the vector through one write port. A two-bit operation code on that port selects one of three aliases: a plain load, an OR-in of bits, or a clear of bits. The PIL has its own write port, and both registers can be read back at all times.

Vector bit 0 and bit 16 are driven by timer-match logic, which raises them with single-cycle pulses. Their requests are held back whenever the PIL is 14 or higher. Each of bits 1 to 15 raises its request only when its own index is strictly above the PIL. The block does not choose between requests, compute trap vectors or implement the timers.

Top module: `softint_pend`

## Requirements
- R1: After reset the vector, the PIL and every request line are zero.
- R2: A write with operation code 0 (load) replaces the vector with write-data bits 16:0. Data bits above 16 are dropped, and read-back bits above 16 are always zero.
- R3: A write with operation code 1 (set) ORs write-data bits 16:0 into the vector.
- R4: A write with operation code 2 (clear) clears each vector bit whose matching data bit is 1 and leaves every other bit unchanged.
- R5: A write with operation code 3 leaves the vector unchanged.
- R6: Request bit 0 and request bit 16 are high exactly when their vector bit is set and the PIL is below 14.
- R7: For each index i from 1 to 15, request bit i is high exactly when vector bit i is set and i is strictly greater than the PIL.
- R8: A PIL write stores the 4-bit value, and all request lines reflect the new level from the next cycle.
- R9: A tick-match pulse sets vector bit 0 and a system-tick-match pulse sets vector bit 16. When a pulse and a software write occur in the same cycle, the result is the write result ORed with the pulsed bit.
- R10: Registers update on the clock edge that samples a write. The request lines follow combinationally from the registers, so they change in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Vector write strobe |
| regWrOp | input | 2 | Write alias: 0 load, 1 set, 2 clear, 3 no effect |
| regWrData | input | 32 | Vector write data |
| pilWrEn | input | 1 | PIL write strobe |
| pilWrData | input | 4 | PIL write data |
| tickMatch | input | 1 | Tick timer match pulse, sets bit 0 |
| sysTickMatch | input | 1 | System tick timer match pulse, sets bit 16 |
| softintRd | output | 32 | Vector read-back, zero above bit 16 |
| pilRd | output | 4 | PIL read-back |
| intReq | output | 17 | Per-bit interrupt request lines |

## Verification
The assertions take for granted that the operation code is a known value whenever the write strobe is high. They also assume the match pulses are the only hardware source of set bits, so a clear-alias check excludes any bit pulsed in the same cycle. The stimulus drives every input at the falling edge from one task, and it always drives a defined operation code. It deliberately lines up match pulses with clear and load writes, which confirms that the exclusion in the checks is the one real overlap.

// File: rtl/softint_pkg.sv
package softint_pkg;
  localparam int VEC_W    = 17;
  localparam int PIL_W    = 4;
  localparam int DATA_W   = 32;
  localparam int PIL_GATE = 14;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } wr_op_e;

  typedef struct packed {
    logic load;
    logic setBits;
    logic clrBits;
    logic pilLoad;
  } strobe_t;
endpackage

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regWrOp,
  input  logic       pilWrEn,
  output strobe_t    strb
);
  wr_op_e opDec;

  always_comb begin
    opDec        = wr_op_e'(regWrOp);
    strb         = '0;
    strb.pilLoad = pilWrEn;
    if (regWrEn) begin
      unique case (opDec)
        OP_LOAD:  strb.load    = 1'b1;
        OP_SET:   strb.setBits = 1'b1;
        OP_CLEAR: strb.clrBits = 1'b1;
        default:  ;
      endcase
    end
  end

  // R5: at most one vector alias fires, and the reserved code fires none
  p_one_alias_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.setBits, strb.clrBits}));
  p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrOp == 2'd3) |-> !(strb.load || strb.setBits || strb.clrBits));
endmodule

// File: rtl/softint_dp.sv
module softint_dp
  import softint_pkg::*;
#(
  parameter int VW   = VEC_W,
  parameter int PW   = PIL_W,
  parameter int DW   = DATA_W,
  parameter int GATE = PIL_GATE
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [DW-1:0] wrData,
  input  logic [PW-1:0] pilData,
  input  logic [VW-1:0] hwSet,
  output logic [VW-1:0] vecQ,
  output logic [PW-1:0] pilQ,
  output logic [VW-1:0] intReq
);
  localparam int TOP = VW - 1;

  logic [VW-1:0] wrVec;
  logic [VW-1:0] vecBase;
  logic [VW-1:0] vecNext;

  assign wrVec = wrData[VW-1:0];

  always_comb begin
    vecBase = vecQ;
    if (strb.load)         vecBase = wrVec;
    else if (strb.setBits) vecBase = vecQ | wrVec;
    else if (strb.clrBits) vecBase = vecQ & ~wrVec;
    vecNext = vecBase | hwSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
      pilQ <= '0;
    end else begin
      vecQ <= vecNext;
      if (strb.pilLoad) pilQ <= pilData;
    end
  end

  for (genvar i = 0; i < VW; i++) begin : g_req
    if (i == 0 || i == TOP) begin : g_timer
      assign intReq[i] = vecQ[i] && (int'(pilQ) < GATE);
    end else begin : g_level
      assign intReq[i] = vecQ[i] && (i > int'(pilQ));
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> vecQ == ($past(wrVec) | $past(hwSet)));
  p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBits |=> (vecQ & ($past(vecQ) | $past(wrVec))) == ($past(vecQ) | $past(wrVec)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrBits |=> (vecQ & $past(wrVec) & ~$past(hwSet)) == '0);
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.setBits && !strb.clrBits && hwSet == '0) |=> $stable(vecQ));
  p_timer_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pilQ) >= GATE) |-> (!intReq[0] && !intReq[TOP]));
  p_req_subset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intReq & ~vecQ) == '0);
  p_pil_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.pilLoad |=> pilQ == $past(pilData));
  p_pulse_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    hwSet != '0 |=> (vecQ & $past(hwSet)) == $past(hwSet));
endmodule

// File: rtl/softint_pend.sv
module softint_pend
  import softint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regWrOp,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 pilWrEn,
  input  logic [PIL_W-1:0]     pilWrData,
  input  logic                 tickMatch,
  input  logic                 sysTickMatch,
  output logic [DATA_W-1:0]    softintRd,
  output logic [PIL_W-1:0]     pilRd,
  output logic [VEC_W-1:0]     intReq
);
  strobe_t          strb;
  logic [VEC_W-1:0] hwSet;
  logic [VEC_W-1:0] vecQ;

  always_comb begin
    hwSet          = '0;
    hwSet[0]       = tickMatch;
    hwSet[VEC_W-1] = sysTickMatch;
  end

  softint_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regWrOp (regWrOp),
    .pilWrEn (pilWrEn),
    .strb    (strb)
  );

  softint_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .pilData (pilWrData),
    .hwSet   (hwSet),
    .vecQ    (vecQ),
    .pilQ    (pilRd),
    .intReq  (intReq)
  );

  assign softintRd = DATA_W'(vecQ);
endmodule

// File: tb/softint_pend_bench.sv
module softint_pend_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrOp = 2'd0;
  logic [31:0] regWrData = '0;
  logic        pilWrEn = 1'b0;
  logic [3:0]  pilWrData = '0;
  logic        tickMatch = 1'b0;
  logic        sysTickMatch = 1'b0;
  logic [31:0] softintRd;
  logic [3:0]  pilRd;
  logic [16:0] intReq;

  typedef struct {
    logic [31:0] vec;
    logic [3:0]  pil;
    logic [16:0] req;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int failures = 0;
  logic [16:0] mVec = '0;
  logic [3:0]  mPil = '0;
  bit stimDone = 1'b0;

  always #4 clk = ~clk;

  softint_pend u_softint_pend (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrOp(regWrOp),
    .regWrData(regWrData), .pilWrEn(pilWrEn), .pilWrData(pilWrData),
    .tickMatch(tickMatch), .sysTickMatch(sysTickMatch),
    .softintRd(softintRd), .pilRd(pilRd), .intReq(intReq)
  );

  function automatic logic [16:0] modelReq(logic [16:0] v, logic [3:0] p);
    logic [16:0] r = '0;
    r[0]  = v[0]  && (p < 4'd14);
    r[16] = v[16] && (p < 4'd14);
    for (int i = 1; i < 16; i++) r[i] = v[i] && (i > int'(p));
    return r;
  endfunction

  function automatic void compare(exp_t e);
    checks++;
    if (softintRd !== e.vec || pilRd !== e.pil || intReq !== e.req) begin
      failures++;
      $display("FAIL %s: vec=%h pil=%0d req=%h expected vec=%h pil=%0d req=%h",
               e.tag, softintRd, pilRd, intReq, e.vec, e.pil, e.req);
    end
  endfunction

  task automatic doOp(input bit wr, input logic [1:0] op, input logic [31:0] data,
                      input bit pw, input logic [3:0] pv, input bit tk,
                      input bit stk, input string tag);
    logic [16:0] d = data[16:0];
    exp_t e;
    @(negedge clk);
    regWrEn = wr; regWrOp = op; regWrData = data;
    pilWrEn = pw; pilWrData = pv; tickMatch = tk; sysTickMatch = stk;
    if (wr) begin
      case (op)
        2'd0: mVec = d;
        2'd1: mVec = mVec | d;
        2'd2: mVec = mVec & ~d;
        default: ;
      endcase
    end
    if (tk)  mVec[0]  = 1'b1;
    if (stk) mVec[16] = 1'b1;
    if (pw)  mPil = pv;
    e.vec = {15'b0, mVec}; e.pil = mPil; e.req = modelReq(mVec, mPil); e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: results appear one edge after the driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    // R1: reset state
    r.vec = '0; r.pil = '0; r.req = '0; r.tag = "R1 reset";
    compare(r);
    rstN = 1'b1;
    doOp(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 R10 load all ones, upper dropped");
    doOp(0, 2'd0, 0, 1, 4'd14, 0, 0, "R8 R6 pil 14 gates timer bits");
    doOp(0, 2'd0, 0, 1, 4'd13, 0, 0, "R6 R7 pil 13");
    doOp(0, 2'd0, 0, 1, 4'd15, 0, 0, "R7 pil 15 masks all");
    doOp(0, 2'd0, 0, 1, 4'd0, 0, 0, "R8 pil back to 0");
    doOp(1, 2'd2, 32'h0000_8001, 0, 0, 0, 0, "R4 clear bits 15 and 0");
    doOp(1, 2'd1, 32'h0000_0005, 0, 0, 0, 0, "R3 set bits 2 and 0");
    doOp(1, 2'd3, 32'h0000_0000, 0, 0, 0, 0, "R5 reserved op no effect");
    doOp(1, 2'd0, 32'h0000_0000, 1, 4'd5, 0, 0, "R2 load zero with pil 5");
    doOp(1, 2'd1, 32'h0000_0070, 0, 0, 0, 0, "R7 bits 4..6 at pil 5");
    doOp(0, 2'd0, 0, 0, 0, 1, 0, "R9 tick pulse sets bit 0");
    doOp(1, 2'd1, 32'h0001_0000, 0, 0, 0, 0, "R3 set bit 16");
    doOp(1, 2'd2, 32'h0001_0001, 0, 0, 0, 1, "R9 clear with sys tick pulse keeps 16");
    doOp(1, 2'd0, 32'h0000_0002, 0, 0, 1, 0, "R9 load with tick pulse");
    doOp(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, 1, "R5 R9 reserved op plus sys tick");
    doOp(1, 2'd0, 32'hFFFE_0000, 0, 0, 0, 0, "R2 upper-only data loads zero");
    doOp(0, 2'd0, 0, 0, 0, 0, 0, "R10 idle cycle holds");
    repeat (3) @(negedge clk);
    stimDone = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule